// File: doc/BRIEF.md
# Quad-capable SPI target front-end

This block is the serial interface logic on the target side of a SPI memory. It oversamples the chip select, the serial clock and the input-capable data lines in its own system clock domain. It collects an 8-bit instruction, then an address or status bytes depending on the instruction, and sends read data back on one, two or four lines. A byte-wide backend port fetches memory bytes from an external memory model one at a time, at incrementing addresses.

The block holds a small pair of status registers. The first register gives the backend busy flag, a write-enable latch, five protect bits and a guard bit. The second register gives a quad-enable bit. While quad-enable is 0, the line used as IO3 serves as an active-low pause input and the line used as IO2 serves as an active-low write-protect input. While quad-enable is 1, both lines are plain data lines and neither function applies. Instruction and address bits always arrive on IO0. Output-line reads wait a fixed number of dummy clocks after the address.

Top module: `qspi_target_fe`

## Requirements
- R1: While chip select is high, `io_oe` is 0 on every line, and after reset `io_oe` and `be_rd_req` are 0.
- R2: After reset, a transaction is accepted only once chip select has been seen high and then low. Clocks sent while chip select stays low from reset have no effect.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is visible as bit 1 of status register 1.
- R4: Opcode 0x05 returns status register 1, MSB first on IO1, as {guard bit 7, protect bits 6:2, latch bit 1, busy bit 0}. Bit 0 follows `be_busy`. The byte repeats for as long as clocks continue.
- R5: Opcode 0x35 returns status register 2, with quad-enable in bit 1 and all other bits 0. The byte repeats for as long as clocks continue.
- R6: Opcode 0x03 followed by a 24-bit address, MSB first on IO0, returns backend bytes from that address upward. Each byte is sent MSB first on IO1 only, with `io_oe`=0010, and the address wraps at 24 bits.
- R7: Opcode 0x3B uses the address, then 8 dummy clocks, and then sends 2 bits per clock with the higher bit on IO1. `io_oe`=0011 during this phase.
- R8: Opcode 0x6B uses the address, then 8 dummy clocks, and then sends 4 bits per clock with bit 7 on IO3. `io_oe`=1111 during this phase. If quad-enable is 0, the opcode is ignored and no line is driven.
- R9: When quad-enable is 0, IO3 low during a selected transaction sets every `io_oe` to 0 and makes the block ignore the clock. When IO3 goes back high, the transfer resumes at the same bit.
- R10: When quad-enable is 1, IO3 low does not pause a transfer and IO2 low does not block a status write.
- R11: Opcode 0x01 followed by two bytes writes the first byte to bits 7:2 of status register 1 and bit 1 of the second byte to quad-enable, then clears the latch. The write is ignored when the latch is 0. It is also ignored when the guard bit is 1, IO2 is low and quad-enable is 0.
- R12: Raising chip select at any point aborts the current instruction. The next selection starts a new instruction.
- R13: Output data changes only after a falling serial-clock edge and holds its value through the following high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| io0_in | input | 1 | IO0 input: instruction, address and write data |
| io2_in | input | 1 | IO2 input: write-protect (active low) when quad-enable is 0 |
| io3_in | input | 1 | IO3 input: pause (active low) when quad-enable is 0 |
| io_out | output | 4 | Output values for IO3..IO0 |
| io_oe | output | 4 | Output enables for IO3..IO0 |
| be_rd_req | output | 1 | One-cycle backend byte request |
| be_rd_addr | output | 24 | Address of the requested byte |
| be_rd_data | input | 8 | Backend byte, valid the cycle after a request |
| be_busy | input | 1 | Backend busy flag reported in status bit 0 |

## Verification
Single, dual and quad reads run at random addresses and lengths, including a run that wraps a 16-bit address boundary. Each lane width gives different bit orders on the lines, so a wrong lane mapping or shift step shows up as corrupted bytes. Status reads and writes are run with the write-protect and pause pins toggled in both quad-enable states. These runs separate an effective pin function from a repurposed data line. Pause episodes placed at arbitrary bit positions and aborts in the middle of an instruction show whether the bit counter freezes or resets when it should.

// File: rtl/qspi_tgt_pkg.sv
package qspi_tgt_pkg;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR1 = 8'h05;
   localparam logic [7:0] OP_RDSR2 = 8'h35;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_RD1   = 8'h03;
   localparam logic [7:0] OP_RD2   = 8'h3B;
   localparam logic [7:0] OP_RD4   = 8'h6B;

   typedef enum logic [1:0] {
      LN_X1,
      LN_X2,
      LN_X4
   } lane_e;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_DUMMY,
      PH_OUT,
      PH_WDATA,
      PH_SKIP
   } phase_e;

endpackage

// File: rtl/qspi_tgt_sync.sv
module qspi_tgt_sync #(
   parameter int             W       = 5,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/qspi_tgt_regs.sv
module qspi_tgt_regs #(
   parameter logic QE_RESET = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_s,
   input  logic       wp_n_s,
   input  logic       hold_n_s,
   input  logic       busy,
   input  logic       wel_set,
   input  logic       wel_clr,
   input  logic       wr_stat,
   input  logic [5:0] wr_sr1_hi,
   input  logic       wr_qe,
   output logic [7:0] sr1,
   output logic [7:0] sr2,
   output logic       qe,
   output logic       hold_act
);

   logic       wel;
   logic [5:0] hi;
   logic       qe_r;
   logic       wp_block;

   // write-protect is only a pin function while the quad lines are not in use
   assign wp_block = hi[5] && !wp_n_s && !qe_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         hi   <= '0;
         qe_r <= QE_RESET;
      end else begin
         if (wel_set) wel <= 1'b1;
         if (wel_clr) wel <= 1'b0;
         if (wr_stat && wel && !wp_block) begin
            hi   <= wr_sr1_hi;
            qe_r <= wr_qe;
            wel  <= 1'b0;
         end
      end
   end

   assign sr1      = {hi, wel, busy};
   assign sr2      = {6'b0, qe_r, 1'b0};
   assign qe       = qe_r;
   assign hold_act = !cs_n_s && !qe_r && !hold_n_s;

endmodule

// File: rtl/qspi_tgt_ctrl.sv
module qspi_tgt_ctrl
   import qspi_tgt_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DUMMY_CLKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_n_s,
   input  logic              io0_s,
   input  logic              hold_act,
   input  logic              qe,
   input  logic [7:0]        sr1,
   input  logic [7:0]        sr2,
   output logic              wel_set,
   output logic              wel_clr,
   output logic              wr_stat,
   output logic [5:0]        wr_sr1_hi,
   output logic              wr_qe,
   output logic              be_rd_req,
   output logic [ADDR_W-1:0] be_rd_addr,
   input  logic [7:0]        be_rd_data,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe
);

   localparam int CW = $clog2(ADDR_W + DUMMY_CLKS + 1);

   logic              sclk_q;
   logic              armed;
   phase_e            ph;
   lane_e             ln;
   logic [CW-1:0]     bcnt;
   logic [ADDR_W-1:0] shreg;
   logic [ADDR_W-1:0] cap;
   logic [ADDR_W-1:0] nxt_addr;
   logic              stat_src;
   logic              stat_sel2;
   logic [7:0]        oshift;
   logic [7:0]        obuf;
   logic [7:0]        nxt_byte;
   logic [2:0]        ocnt;
   logic              driving;
   logic              req_q;
   logic              run;
   logic              rise;
   logic              fall;

   function automatic logic [3:0] pin_map(lane_e l, logic [7:0] b);
      case (l)
         LN_X2:   return {2'b00, b[7:6]};
         LN_X4:   return b[7:4];
         default: return {2'b00, b[7], 1'b0};
      endcase
   endfunction

   function automatic logic [7:0] lane_shift(lane_e l, logic [7:0] b);
      case (l)
         LN_X2:   return {b[5:0], 2'b00};
         LN_X4:   return {b[3:0], 4'b0000};
         default: return {b[6:0], 1'b0};
      endcase
   endfunction

   function automatic logic [2:0] chunk_last(lane_e l);
      case (l)
         LN_X2:   return 3'd3;
         LN_X4:   return 3'd1;
         default: return 3'd7;
      endcase
   endfunction

   function automatic logic [3:0] oe_mask(lane_e l);
      case (l)
         LN_X2:   return 4'b0011;
         LN_X4:   return 4'b1111;
         default: return 4'b0010;
      endcase
   endfunction

   assign run  = !cs_n_s && armed && !hold_act;
   assign rise = run && sclk_s && !sclk_q;
   assign fall = run && !sclk_s && sclk_q;
   assign cap  = {shreg[ADDR_W-2:0], io0_s};

   always_comb begin
      if (ocnt == 3'd0) nxt_byte = stat_src ? (stat_sel2 ? sr2 : sr1) : obuf;
      else              nxt_byte = lane_shift(ln, oshift);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q     <= 1'b0;
         armed      <= 1'b0;
         ph         <= PH_CMD;
         ln         <= LN_X1;
         bcnt       <= '0;
         shreg      <= '0;
         nxt_addr   <= '0;
         stat_src   <= 1'b0;
         stat_sel2  <= 1'b0;
         oshift     <= '0;
         obuf       <= '0;
         ocnt       <= '0;
         driving    <= 1'b0;
         req_q      <= 1'b0;
         wel_set    <= 1'b0;
         wel_clr    <= 1'b0;
         wr_stat    <= 1'b0;
         wr_sr1_hi  <= '0;
         wr_qe      <= 1'b0;
         be_rd_req  <= 1'b0;
         be_rd_addr <= '0;
         io_out     <= '0;
         io_oe      <= '0;
      end else begin
         sclk_q    <= sclk_s;
         wel_set   <= 1'b0;
         wel_clr   <= 1'b0;
         wr_stat   <= 1'b0;
         be_rd_req <= 1'b0;
         req_q     <= be_rd_req;
         if (req_q) obuf <= be_rd_data;

         if (cs_n_s) begin
            armed   <= 1'b1;
            ph      <= PH_CMD;
            ln      <= LN_X1;
            bcnt    <= '0;
            ocnt    <= '0;
            driving <= 1'b0;
         end else if (rise) begin
            shreg <= cap;
            bcnt  <= bcnt + 1'b1;
            case (ph)
               PH_CMD: begin
                  if (bcnt == CW'(7)) begin
                     bcnt <= '0;
                     ph   <= PH_SKIP;
                     case (cap[7:0])
                        OP_WREN: wel_set <= 1'b1;
                        OP_WRDI: wel_clr <= 1'b1;
                        OP_RDSR1, OP_RDSR2: begin
                           ph        <= PH_OUT;
                           ln        <= LN_X1;
                           stat_src  <= 1'b1;
                           stat_sel2 <= (cap[7:0] == OP_RDSR2);
                        end
                        OP_WRSR: ph <= PH_WDATA;
                        OP_RD1: begin
                           ph       <= PH_ADDR;
                           ln       <= LN_X1;
                           stat_src <= 1'b0;
                        end
                        OP_RD2: begin
                           ph       <= PH_ADDR;
                           ln       <= LN_X2;
                           stat_src <= 1'b0;
                        end
                        OP_RD4: begin
                           if (qe) begin
                              ph       <= PH_ADDR;
                              ln       <= LN_X4;
                              stat_src <= 1'b0;
                           end
                        end
                        default: ;
                     endcase
                  end
               end
               PH_ADDR: begin
                  if (bcnt == CW'(ADDR_W-1)) begin
                     bcnt <= '0;
                     if (ln == LN_X1) begin
                        ph         <= PH_OUT;
                        be_rd_req  <= 1'b1;
                        be_rd_addr <= cap;
                        nxt_addr   <= cap + 1'b1;
                     end else begin
                        ph       <= PH_DUMMY;
                        nxt_addr <= cap;
                     end
                  end
               end
               PH_DUMMY: begin
                  if (bcnt == CW'(DUMMY_CLKS-1)) begin
                     bcnt       <= '0;
                     ph         <= PH_OUT;
                     be_rd_req  <= 1'b1;
                     be_rd_addr <= nxt_addr;
                     nxt_addr   <= nxt_addr + 1'b1;
                  end
               end
               PH_WDATA: begin
                  if (bcnt == CW'(15)) begin
                     bcnt      <= '0;
                     ph        <= PH_SKIP;
                     wr_stat   <= 1'b1;
                     wr_sr1_hi <= cap[15:10];
                     wr_qe     <= cap[1];
                  end
               end
               default: ;
            endcase
         end else if (fall && ph == PH_OUT) begin
            driving <= 1'b1;
            oshift  <= nxt_byte;
            io_out  <= pin_map(ln, nxt_byte);
            if (ocnt == 3'd0) begin
               ocnt <= chunk_last(ln);
               if (!stat_src) begin
                  be_rd_req  <= 1'b1;
                  be_rd_addr <= nxt_addr;
                  nxt_addr   <= nxt_addr + 1'b1;
               end
            end else begin
               ocnt <= ocnt - 1'b1;
            end
         end

         io_oe <= (!cs_n_s && !hold_act && driving && ph == PH_OUT) ? oe_mask(ln) : 4'b0000;
      end
   end

endmodule

// File: rtl/qspi_target_fe.sv
module qspi_target_fe #(
   parameter int   ADDR_W      = 24,
   parameter int   DUMMY_CLKS  = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic QE_RESET    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              io0_in,
   input  logic              io2_in,
   input  logic              io3_in,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   output logic              be_rd_req,
   output logic [ADDR_W-1:0] be_rd_addr,
   input  logic [7:0]        be_rd_data,
   input  logic              be_busy
);

   localparam int         SW      = 5;
   localparam logic [4:0] SYNC_RV = 5'b00110;

   initial begin
      assert (ADDR_W >= 16 && ADDR_W <= 32 && (ADDR_W % 8) == 0)
         else $error("ADDR_W must be a byte multiple between 16 and 32");
      assert (DUMMY_CLKS >= 1 && DUMMY_CLKS <= 32)
         else $error("DUMMY_CLKS out of range");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 3)
         else $error("SYNC_STAGES out of range");
   end

   logic [SW-1:0] pins_s;
   logic          sclk_s, cs_n_s, hold_n_s, wp_n_s, io0_s;
   logic          hold_act, qe;
   logic [7:0]    sr1, sr2;
   logic          wel_set, wel_clr, wr_stat, wr_qe;
   logic [5:0]    wr_sr1_hi;

   qspi_tgt_sync #(
      .W       (SW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RV)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, cs_n, io3_in, io2_in, io0_in}),
      .q     (pins_s)
   );

   assign {sclk_s, cs_n_s, hold_n_s, wp_n_s, io0_s} = pins_s;

   qspi_tgt_regs #(
      .QE_RESET (QE_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (cs_n_s),
      .wp_n_s    (wp_n_s),
      .hold_n_s  (hold_n_s),
      .busy      (be_busy),
      .wel_set   (wel_set),
      .wel_clr   (wel_clr),
      .wr_stat   (wr_stat),
      .wr_sr1_hi (wr_sr1_hi),
      .wr_qe     (wr_qe),
      .sr1       (sr1),
      .sr2       (sr2),
      .qe        (qe),
      .hold_act  (hold_act)
   );

   qspi_tgt_ctrl #(
      .ADDR_W     (ADDR_W),
      .DUMMY_CLKS (DUMMY_CLKS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (sclk_s),
      .cs_n_s     (cs_n_s),
      .io0_s      (io0_s),
      .hold_act   (hold_act),
      .qe         (qe),
      .sr1        (sr1),
      .sr2        (sr2),
      .wel_set    (wel_set),
      .wel_clr    (wel_clr),
      .wr_stat    (wr_stat),
      .wr_sr1_hi  (wr_sr1_hi),
      .wr_qe      (wr_qe),
      .be_rd_req  (be_rd_req),
      .be_rd_addr (be_rd_addr),
      .be_rd_data (be_rd_data),
      .io_out     (io_out),
      .io_oe      (io_oe)
   );

endmodule

// File: rtl/qspi_target_fe_chk.sv
module qspi_target_fe_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n_s,
   input logic       hold_act,
   input logic       sclk_s,
   input logic       qe,
   input logic [3:0] io_oe,
   input logic [3:0] io_out,
   input logic       be_rd_req
);

   // R1
   cs_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (io_oe == 4'b0000));

   // R9
   hold_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_act |=> (io_oe == 4'b0000));

   // R7
   oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

   // R8
   quad_needs_qe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe == 4'b1111) |-> qe);

   // R6
   req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      be_rd_req |=> !be_rd_req);

   // R13
   out_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(io_out) |-> !$past(sclk_s));

endmodule

bind qspi_target_fe qspi_target_fe_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n_s    (cs_n_s),
   .hold_act  (hold_act),
   .sclk_s    (sclk_s),
   .qe        (qe),
   .io_oe     (io_oe),
   .io_out    (io_out),
   .be_rd_req (be_rd_req)
);

// File: tb/qspi_target_fe_tb.sv
module qspi_target_fe_tb;

   localparam int H = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b0;
   logic        io0 = 1'b0;
   logic        wp_pin = 1'b1;
   logic        hold_pin = 1'b1;
   logic        be_busy = 1'b0;
   logic [3:0]  io_out, io_oe;
   logic        be_rd_req;
   logic [23:0] be_rd_addr;
   logic [7:0]  be_rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] mem_f(logic [23:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hC3;
   endfunction

   function automatic logic [3:0] mask_of(int w);
      return (w == 4) ? 4'b1111 : (w == 2) ? 4'b0011 : 4'b0010;
   endfunction

   assign be_rd_data = mem_f(be_rd_addr);

   qspi_target_fe u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk       (sclk),
      .cs_n       (cs_n),
      .io0_in     (io0),
      .io2_in     (wp_pin),
      .io3_in     (hold_pin),
      .io_out     (io_out),
      .io_oe      (io_oe),
      .be_rd_req  (be_rd_req),
      .be_rd_addr (be_rd_addr),
      .be_rd_data (be_rd_data),
      .be_busy    (be_busy)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic sclk_bit(input logic d0, output logic [3:0] o, output logic [3:0] oe, output logic [3:0] o_late);
      @(negedge clk);
      io0 = d0;
      repeat (H) @(negedge clk);
      o  = io_out;
      oe = io_oe;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      o_late = io_out;
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic [3:0] o, oe, ol;
      for (int i = 7; i >= 0; i--) sclk_bit(b[i], o, oe, ol);
   endtask

   task automatic cs_low();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic cs_high();
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (2*H) @(negedge clk);
   endtask

   task automatic hold_episode();
      @(negedge clk);
      hold_pin = 1'b0;
      repeat (H) @(negedge clk);
      chk(io_oe == 4'b0000, "R9 pause tri-state", io_oe, 0);
      for (int k = 0; k < 3; k++) begin
         sclk = 1'b1;
         io0 = 1'($urandom);
         repeat (H) @(negedge clk);
         sclk = 1'b0;
         repeat (H) @(negedge clk);
      end
      chk(io_oe == 4'b0000, "R9 pause held", io_oe, 0);
      hold_pin = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   // receive one byte at width w; hold_at counts chunks from the start of data
   task automatic recv_byte(input int w, inout int pos, input int hold_at,
                            output logic [7:0] b, output logic [3:0] oe_or,
                            output logic [3:0] oe_and, output bit stable_ok);
      logic [3:0] o, oe, ol;
      b = '0; oe_or = '0; oe_and = '1; stable_ok = 1;
      for (int c = 0; c < 8 / w; c++) begin
         if (pos == hold_at) hold_episode();
         sclk_bit(1'($urandom), o, oe, ol);
         pos++;
         oe_or  |= oe;
         oe_and &= oe;
         if (o != ol) stable_ok = 0;
         case (w)
            4:       b = {b[3:0], o};
            2:       b = {b[5:0], o[1:0]};
            default: b = {b[6:0], o[1]};
         endcase
      end
   endtask

   task automatic do_read(input logic [7:0] op, input logic [23:0] addr, input int n,
                          input int w, input int hold_at, input bit expect_idle, input string tag);
      logic [7:0] b;
      logic [3:0] oo, oa;
      bit st;
      int pos = 0;
      cs_low();
      send_byte(op);
      send_byte(addr[23:16]);
      send_byte(addr[15:8]);
      send_byte(addr[7:0]);
      if (w != 1) send_byte(8'($urandom));
      for (int i = 0; i < n; i++) begin
         recv_byte(w, pos, hold_at, b, oo, oa, st);
         if (expect_idle) begin
            chk(oo == 4'b0000, {tag, " ignored, no drive"}, oo, 0);
         end else begin
            chk(b == mem_f(addr + 24'(i)), {tag, " data"}, b, mem_f(addr + 24'(i)));
            chk(oo == mask_of(w) && oa == mask_of(w), {tag, " enables"}, {oo, oa}, {mask_of(w), mask_of(w)});
            chk(st, "R13 held through high phase", st, 1);
         end
      end
      cs_high();
   endtask

   task automatic read_sr(input logic [7:0] op, input logic [7:0] exp, input string tag);
      logic [7:0] b;
      logic [3:0] oo, oa;
      bit st;
      int pos = 0;
      cs_low();
      send_byte(op);
      for (int i = 0; i < 2; i++) begin
         recv_byte(1, pos, -1, b, oo, oa, st);
         chk(b == exp, tag, b, exp);
      end
      cs_high();
   endtask

   task automatic cmd1(input logic [7:0] op);
      cs_low();
      send_byte(op);
      cs_high();
   endtask

   task automatic wrsr(input logic [7:0] a, input logic [7:0] b);
      cs_low();
      send_byte(8'h01);
      send_byte(a);
      send_byte(b);
      cs_high();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog all requirements act=timeout exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(io_oe == 4'b0000, "R1 reset enables", io_oe, 0);
      chk(be_rd_req == 1'b0, "R1 reset request", be_rd_req, 0);

      // R2 chip select low since reset: clocks have no effect
      send_byte(8'h06);
      cs_high();
      read_sr(8'h05, 8'h00, "R2 unarmed write enable ignored");

      // R3
      cmd1(8'h06);
      read_sr(8'h05, 8'h02, "R3 latch set");
      cmd1(8'h04);
      read_sr(8'h05, 8'h00, "R3 latch cleared");

      // R4 busy reported live
      be_busy = 1'b1;
      read_sr(8'h05, 8'h01, "R4 busy bit");
      be_busy = 1'b0;

      // R5
      read_sr(8'h35, 8'h00, "R5 second status");

      // R6 / R7
      do_read(8'h03, 24'h123456, 3, 1, -1, 0, "R6 single read");
      do_read(8'h3B, 24'hABCDEF, 2, 2, -1, 0, "R7 dual read");

      // R8 quad with quad-enable clear is ignored
      do_read(8'h6B, 24'h000100, 1, 4, -1, 1, "R8");

      // R11 status writes
      wrsr(8'h84, 8'h02);
      read_sr(8'h35, 8'h00, "R11 no latch, no write");
      cmd1(8'h06);
      wrsr(8'h84, 8'h00);
      read_sr(8'h05, 8'h84, "R11 write applied, latch cleared");
      wp_pin = 1'b0;
      cmd1(8'h06);
      wrsr(8'h00, 8'h02);
      read_sr(8'h05, 8'h86, "R11 protected write blocked");
      read_sr(8'h35, 8'h00, "R11 protected qe unchanged");
      wp_pin = 1'b1;
      wrsr(8'h84, 8'h02);
      read_sr(8'h35, 8'h02, "R11 quad-enable written");

      // R8 quad read, crossing a 16-bit boundary
      do_read(8'h6B, 24'h00FFFE, 4, 4, -1, 0, "R8 quad read");

      // R10 pins act as data once quad-enable is set
      hold_pin = 1'b0;
      do_read(8'h6B, 24'h3C0010, 2, 4, -1, 0, "R10 pause line low in quad");
      hold_pin = 1'b1;
      wp_pin = 1'b0;
      cmd1(8'h06);
      wrsr(8'h88, 8'h02);
      read_sr(8'h05, 8'h88, "R10 protect pin ignored in quad");
      wp_pin = 1'b1;

      // random mix, all widths
      for (int i = 0; i < 14; i++) begin
         int sel = $urandom_range(0, 2);
         int n = $urandom_range(1, 4);
         logic [23:0] a = 24'($urandom);
         if (sel == 0)      do_read(8'h03, a, n, 1, -1, 0, "R6 random single");
         else if (sel == 1) do_read(8'h3B, a, n, 2, -1, 0, "R7 random dual");
         else               do_read(8'h6B, a, n, 4, -1, 0, "R8 random quad");
      end

      // R12 aborts
      cs_low();
      send_byte(8'h03);
      send_byte(8'h55);
      cs_high();
      read_sr(8'h05, 8'h88, "R12 status after aborted address");
      begin
         logic [3:0] o, oe, ol;
         cs_low();
         send_byte(8'h03);
         send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
         for (int k = 0; k < 12; k++) sclk_bit(1'b0, o, oe, ol);
         cs_high();
         chk(io_oe == 4'b0000, "R12 released after abort", io_oe, 0);
      end
      do_read(8'h03, 24'h0A0B0C, 2, 1, -1, 0, "R12 read after abort");

      // back to pin functions, then pause tests
      cmd1(8'h06);
      wrsr(8'h00, 8'h00);
      read_sr(8'h35, 8'h00, "R11 quad-enable cleared");
      do_read(8'h03, 24'h777000, 2, 1, 10, 0, "R9 single with pause");
      do_read(8'h3B, 24'h600FFF, 2, 2, 3, 0, "R9 dual with pause");
      for (int i = 0; i < 8; i++) begin
         int w = ($urandom_range(0, 1) == 0) ? 1 : 2;
         int n = $urandom_range(1, 3);
         int hp = $urandom_range(0, n * (8 / w) - 1);
         do_read((w == 1) ? 8'h03 : 8'h3B, 24'($urandom), n, w, hp, 0, "R9 random pause");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule